// File: doc/BRIEF.md
# Handshake-Qualified Packet Framing Monitor

This block sits beside a streaming link that uses valid/busy flow control and watches the command code of each transferred beat. A beat is counted only on a rising clock edge where the sender holds valid high and the receiver holds busy low. Cycles where the receiver is busy, and cycles with no valid, are stalls and leave every piece of monitor state untouched.

From the accepted beats the monitor tracks the packet grammar: one opening beat, any number of body beats, then one closing beat. Two kinds of framing violation are reported. A second opening beat inside an open packet is a nested open. Any body or closing beat seen while no packet is open is an orphan. Each kind sets its own sticky flag, and every violation also produces a one-cycle pulse. Completed packets are counted in a saturating counter. The monitor never drives the link. It only observes the command field, and the payload bits are ignored.

Top module: `pkt_frame_checker`

## Requirements
- R1: A beat is accepted only on a rising edge with valid=1 and busy=0. On any other edge `in_packet`, both error flags and `pkt_count` keep their values, and `err_pulse` is low in the following cycle.
- R2: The beat code is `cmd[CMD_W-1:CMD_W-2]`: 2'b01 opens, 2'b10 is body, 2'b11 closes, and 2'b00 is treated as body. The lower command bits have no effect. An accepted opening beat while idle sets `in_packet` in the next cycle, with no error.
- R3: Accepted body beats (code 2'b10 or 2'b00) inside an open packet keep `in_packet` high and raise no error.
- R4: An accepted closing beat inside an open packet clears `in_packet` in the next cycle and increments `pkt_count` by one.
- R5: An accepted opening beat inside an open packet sets `err_nested`. `in_packet` stays high, so the new packet is tracked, and `pkt_count` does not change.
- R6: An accepted body or closing beat while idle sets `err_orphan`. `in_packet` stays low and `pkt_count` does not change.
- R7: `err_pulse` is high for exactly the one cycle after each violating beat (R5 or R6) and low in every other cycle.
- R8: `pkt_count` saturates at 2^CNT_W-1. Further completed packets leave it at that value.
- R9: A synchronous reset (`rst`=1 at a rising edge) leaves, from the next cycle on, `in_packet`, `err_nested`, `err_orphan` and `err_pulse` low and `pkt_count` zero.
- R10: `err_nested` and `err_orphan` stay set once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Sender has a beat on the link |
| busy | input | 1 | Receiver refuses the beat this cycle |
| cmd | input | CMD_W (24) | Command field; the top two bits hold the beat code |
| in_packet | output | 1 | A packet is currently open |
| err_nested | output | 1 | Sticky: opening beat seen inside an open packet |
| err_orphan | output | 1 | Sticky: body or closing beat seen outside a packet |
| err_pulse | output | 1 | One-cycle pulse after any violating beat |
| pkt_count | output | CNT_W (16) | Saturating count of completed packets |

## Verification
A wrong framing state shows on `in_packet` one cycle after the beat that corrupted it. It then shows as a spurious or a missing error on the very next accepted beat, or as a `pkt_count` that fails to advance on the next closing beat. A stall that leaks into the state changes `in_packet`, the flags or the count one cycle after the stalled edge. The bench therefore checks every output after every edge of a stream that mixes stalls, idle cycles, both violations and packets with and without body beats. The stream is followed by a mid-packet reset and a saturation run on a narrow counter.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

  typedef enum logic [1:0] {
    CODE_NONE   = 2'b00,
    CODE_OPEN   = 2'b01,
    CODE_BODY   = 2'b10,
    CODE_CLOSE  = 2'b11
  } beat_code_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } frame_state_e;

  typedef struct packed {
    logic opens;
    logic closes;
    logic carries;
  } beat_class_t;

  function automatic beat_class_t classify(input logic [1:0] code);
    beat_class_t c;
    c.opens   = (beat_code_e'(code) == CODE_OPEN);
    c.closes  = (beat_code_e'(code) == CODE_CLOSE);
    c.carries = (beat_code_e'(code) == CODE_BODY) || (beat_code_e'(code) == CODE_NONE);
    return c;
  endfunction

  function automatic logic handshake_taken(input logic v, input logic b);
    return v && !b;
  endfunction

endpackage

// File: rtl/beat_decode.sv
module beat_decode
  import pkt_frame_pkg::*;
#(
  parameter int CMD_W = 24
) (
  input  logic             valid,
  input  logic             busy,
  input  logic [CMD_W-1:0] cmd,
  output logic             accept,
  output beat_class_t      cls
);
  localparam int CODE_HI = CMD_W - 1;
  localparam int CODE_LO = CMD_W - 2;

  logic unused_payload;
  assign unused_payload = ^cmd[CODE_LO-1:0];

  assign accept = handshake_taken(valid, busy);
  assign cls    = classify(cmd[CODE_HI:CODE_LO]);
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
  import pkt_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        accept,
  input  beat_class_t cls,
  output logic        in_packet,
  output logic        ev_close,
  output logic        ev_nested,
  output logic        ev_orphan
);
  frame_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    ev_close  = 1'b0;
    ev_nested = 1'b0;
    ev_orphan = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_IDLE: begin
          if (cls.opens) state_d = ST_OPEN;
          else           ev_orphan = 1'b1;
        end
        ST_OPEN: begin
          if (cls.opens) begin
            ev_nested = 1'b1;
          end else if (cls.closes) begin
            ev_close = 1'b1;
            state_d  = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign in_packet = (state_q == ST_OPEN);
endmodule

// File: rtl/error_flags.sv
module error_flags (
  input  logic clk,
  input  logic rst,
  input  logic ev_nested,
  input  logic ev_orphan,
  output logic err_nested,
  output logic err_orphan,
  output logic err_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_nested <= 1'b0;
      err_orphan <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      err_nested <= err_nested | ev_nested;
      err_orphan <= err_orphan | ev_orphan;
      err_pulse  <= ev_nested | ev_orphan;
    end
  end
endmodule

// File: rtl/pkt_counter.sv
module pkt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_close,
  output logic [CNT_W-1:0] pkt_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v, input logic inc);
    if (inc && v != CNT_MAX) return v + 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) pkt_count <= '0;
    else     pkt_count <= sat_step(pkt_count, ev_close);
  end
endmodule

// File: rtl/pkt_frame_checker.sv
module pkt_frame_checker
  import pkt_frame_pkg::*;
#(
  parameter int CMD_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             busy,
  input  logic [CMD_W-1:0] cmd,
  output logic             in_packet,
  output logic             err_nested,
  output logic             err_orphan,
  output logic             err_pulse,
  output logic [CNT_W-1:0] pkt_count
);
  logic        beat_accept;
  beat_class_t beat_cls;
  logic        beat_is_open;
  logic        beat_is_close;
  logic        ev_close;
  logic        ev_nested;
  logic        ev_orphan;

  beat_decode #(.CMD_W(CMD_W)) u_decode (
    .valid  (valid),
    .busy   (busy),
    .cmd    (cmd),
    .accept (beat_accept),
    .cls    (beat_cls)
  );

  assign beat_is_open  = beat_cls.opens;
  assign beat_is_close = beat_cls.closes;

  frame_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .accept    (beat_accept),
    .cls       (beat_cls),
    .in_packet (in_packet),
    .ev_close  (ev_close),
    .ev_nested (ev_nested),
    .ev_orphan (ev_orphan)
  );

  error_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .ev_nested  (ev_nested),
    .ev_orphan  (ev_orphan),
    .err_nested (err_nested),
    .err_orphan (err_orphan),
    .err_pulse  (err_pulse)
  );

  pkt_counter #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .ev_close  (ev_close),
    .pkt_count (pkt_count)
  );
endmodule

// File: rtl/pkt_frame_props.sv
module pkt_frame_props #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             beat_accept,
  input logic             beat_is_open,
  input logic             beat_is_close,
  input logic             in_packet,
  input logic             err_nested,
  input logic             err_orphan,
  input logic             err_pulse,
  input logic [CNT_W-1:0] pkt_count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r1_stall_inert: assert property (@(posedge clk) disable iff (rst)
    !beat_accept |=> ($stable(in_packet) && $stable(pkt_count) && $stable(err_nested)
                      && $stable(err_orphan) && !err_pulse));

  a_r2_open_from_idle: assert property (@(posedge clk) disable iff (rst)
    (beat_accept && beat_is_open && !in_packet) |=> (in_packet && !err_pulse));

  a_r3_body_keeps_open: assert property (@(posedge clk) disable iff (rst)
    (beat_accept && !beat_is_open && !beat_is_close && in_packet) |=> (in_packet && !err_pulse));

  a_r4_close_counts: assert property (@(posedge clk) disable iff (rst)
    (beat_accept && beat_is_close && in_packet && pkt_count != TOP)
      |=> (!in_packet && pkt_count == CNT_W'($past(pkt_count) + 1'b1)));

  a_r5_nested_resync: assert property (@(posedge clk) disable iff (rst)
    (beat_accept && beat_is_open && in_packet) |=> (err_nested && in_packet && err_pulse && $stable(pkt_count)));

  a_r6_orphan: assert property (@(posedge clk) disable iff (rst)
    (beat_accept && !beat_is_open && !in_packet) |=> (err_orphan && !in_packet && err_pulse && $stable(pkt_count)));

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> (!err_pulse || $past(beat_accept)));

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (pkt_count == TOP) |=> (pkt_count == TOP));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!in_packet && !err_nested && !err_orphan && !err_pulse && pkt_count == '0));

  a_r10_sticky_nested: assert property (@(posedge clk) disable iff (rst)
    err_nested |=> err_nested);

  a_r10_sticky_orphan: assert property (@(posedge clk) disable iff (rst)
    err_orphan |=> err_orphan);
endmodule

bind pkt_frame_checker pkt_frame_props #(.CNT_W(CNT_W)) u_props (
  .clk           (clk),
  .rst           (rst),
  .beat_accept   (beat_accept),
  .beat_is_open  (beat_is_open),
  .beat_is_close (beat_is_close),
  .in_packet     (in_packet),
  .err_nested    (err_nested),
  .err_orphan    (err_orphan),
  .err_pulse     (err_pulse),
  .pkt_count     (pkt_count)
);

// File: tb/pkt_frame_checker_tb_top.sv
`timescale 1ns/1ps
module pkt_frame_checker_tb_top;
  localparam int CMD_W = 24;
  localparam int CNT_W = 16;
  localparam int SAT_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid = 1'b0;
  logic busy = 1'b0;
  logic [CMD_W-1:0] cmd = '0;
  logic in_packet, err_nested, err_orphan, err_pulse;
  logic [CNT_W-1:0] pkt_count;
  logic s_in, s_nest, s_orph, s_pulse;
  logic [SAT_W-1:0] s_count;

  always #2 clk = ~clk;

  pkt_frame_checker #(.CMD_W(CMD_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .valid(valid), .busy(busy), .cmd(cmd),
    .in_packet(in_packet), .err_nested(err_nested), .err_orphan(err_orphan),
    .err_pulse(err_pulse), .pkt_count(pkt_count)
  );

  pkt_frame_checker #(.CMD_W(CMD_W), .CNT_W(SAT_W)) dut_sat (
    .clk(clk), .rst(rst), .valid(valid), .busy(busy), .cmd(cmd),
    .in_packet(s_in), .err_nested(s_nest), .err_orphan(s_orph),
    .err_pulse(s_pulse), .pkt_count(s_count)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  // row: valid, busy, code[1:0], exp in/nested/orphan/pulse, exp count[3:0], tag[3:0]
  localparam int ROWS = 17;
  localparam logic [15:0] VEC [ROWS] = '{
    {1'b1,1'b0,2'b01, 4'b1000, 4'd0, 4'd2},
    {1'b1,1'b1,2'b11, 4'b1000, 4'd0, 4'd1},
    {1'b0,1'b0,2'b11, 4'b1000, 4'd0, 4'd1},
    {1'b1,1'b0,2'b10, 4'b1000, 4'd0, 4'd3},
    {1'b1,1'b0,2'b00, 4'b1000, 4'd0, 4'd3},
    {1'b1,1'b0,2'b11, 4'b0000, 4'd1, 4'd4},
    {1'b1,1'b0,2'b01, 4'b1000, 4'd1, 4'd2},
    {1'b1,1'b0,2'b11, 4'b0000, 4'd2, 4'd4},
    {1'b1,1'b0,2'b10, 4'b0011, 4'd2, 4'd6},
    {1'b0,1'b0,2'b10, 4'b0010, 4'd2, 4'd7},
    {1'b1,1'b0,2'b11, 4'b0011, 4'd2, 4'd6},
    {1'b1,1'b1,2'b10, 4'b0010, 4'd2, 4'd1},
    {1'b1,1'b0,2'b01, 4'b1010, 4'd2, 4'd10},
    {1'b1,1'b0,2'b01, 4'b1111, 4'd2, 4'd5},
    {1'b1,1'b0,2'b10, 4'b1110, 4'd2, 4'd7},
    {1'b1,1'b0,2'b11, 4'b0110, 4'd3, 4'd5},
    {1'b1,1'b1,2'b01, 4'b0110, 4'd3, 4'd1}
  };

  function automatic string tag(input int k);
    case (k)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [3:0] flags, input logic [31:0] cnt);
    check(req, "state/flags/pulse", {28'd0, in_packet, err_nested, err_orphan, err_pulse}, {28'd0, flags});
    check(req, "pkt_count", {16'd0, pkt_count}, cnt);
  endtask

  task automatic drive(input logic v, input logic b, input logic [1:0] code, input int salt);
    valid = v;
    busy  = b;
    cmd   = {code, 22'(salt * 32'h0001_3A5B)};
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R9", 4'b0000, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < ROWS; i++) begin
      drive(VEC[i][15], VEC[i][14], VEC[i][13:12], i);
      step();
      check_all(tag(int'(VEC[i][3:0])), VEC[i][11:8], {28'd0, VEC[i][7:4]});
    end

    // R9: reset while a packet is open and both flags set
    drive(1'b1, 1'b0, 2'b01, 99);
    step();
    check("R9", "open before reset", {31'd0, in_packet}, 32'd1);
    rst = 1'b1;
    drive(1'b0, 1'b0, 2'b00, 0);
    step();
    rst = 1'b0;
    check_all("R9", 4'b0000, 32'd0);
    check("R9", "narrow count", {29'd0, s_count}, 32'd0);

    // R8: nine packets, narrow counter stops at 7
    for (int p = 0; p < 9; p++) begin
      drive(1'b1, 1'b0, 2'b01, p);
      step();
      drive(1'b1, 1'b0, 2'b11, p + 7);
      step();
      if (p == 6) check("R8", "narrow count at top", {29'd0, s_count}, 32'd7);
    end
    drive(1'b0, 1'b0, 2'b00, 0);
    step();
    check("R8", "narrow count saturated", {29'd0, s_count}, 32'd7);
    check("R4", "wide count", {16'd0, pkt_count}, 32'd9);
    check("R8", "narrow no error", {31'd0, s_pulse | s_nest | s_orph}, 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule